// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block turns a 32-bit virtual address into a physical address, using a small set-associative array of translation entries held in on-chip RAM. Instruction fetches and data reads or writes all use the same array. Each entry pairs a tag with a data part. The tag holds a 20-bit virtual page number, a process identifier and a global flag. The data part holds a physical frame number and four flags: cacheable, readable, writable and executable. A lookup reads one set from every way, compares the tags and returns the frame joined to the untouched 12-bit page offset. Along with it the block returns a miss indication, the effective cacheable flag and a permission-fault indication.

Lookups use a valid/ready request channel and a valid/ready response channel. The pipeline is two stages deep: a RAM read, then a registered compare and result. Back-pressure stalls the whole pipeline. `req_ready` is high exactly when the response register is empty or is being drained in the same cycle, and a presented response holds steady until `rsp_ready` takes it. Software fills entries through a plain write port and names the way itself, because the hardware has no replacement policy. Entries carry no valid bit. Software retires an entry by loading a page number that is never accessed. If two ways of a set match the same address, the result is undefined, and the design returns the lowest-numbered matching way.

Top module: `xlat_buffer`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` is 0 and `req_ready` is 1 until a request is accepted.
- R2: A request accepted on a clock edge has its response registered on the next edge. On a hit, `rsp_paddr` equals the stored frame number concatenated with `req_vaddr[11:0]`.
- R3: If no way of the addressed set holds a matching tag, then `rsp_miss` is 1 and `rsp_paddr`, `rsp_cacheable` and `rsp_fault` are all 0. The set index is `req_vaddr[15:12]`, which is the low four bits of the page number.
- R4: An entry whose global flag is 0 matches only when its stored identifier equals `cur_pid` as sampled on the accepting edge. Otherwise the lookup misses.
- R5: An entry whose global flag is 1 matches on the page number alone, whatever the value of `cur_pid`.
- R6: `req_kind` is encoded as 00 = fetch, 01 = read, 10 = write and 11 = read. On a hit, `rsp_fault` is 1 when the entry lacks the executable flag for a fetch, the writable flag for a write, or the readable flag for a read.
- R7: On a hit, `rsp_cacheable` follows the entry's cacheable flag. The exception is a read or a write with `req_io` = 1, which forces `rsp_cacheable` to 0. Fetches ignore `req_io`.
- R8: A load writes the entry in way `ld_way` of set `ld_vpn[3:0]` and leaves every other way of that set unchanged. Lookups accepted after the load edge see the new entry.
- R9: Loading an unused page number into a way makes the address that entry used to translate miss.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, every response output holds its value and `req_ready` is 0. Responses leave in the order their requests were accepted, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_pid | input | PID_W | Identifier of the running process |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 read |
| req_io | input | 1 | Uncached I/O data access; clears cacheable for reads and writes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PFN_W+12 | Translated physical address, 0 on miss |
| rsp_miss | output | 1 | No matching entry |
| rsp_cacheable | output | 1 | Effective cacheable flag |
| rsp_fault | output | 1 | Entry forbids the requested access |
| ld_en | input | 1 | Write one entry this cycle |
| ld_way | input | log2(NUM_WAYS) | Way to write |
| ld_vpn | input | 20 | Page number of the new entry; low bits pick the set |
| ld_pid | input | PID_W | Process identifier of the new entry |
| ld_global | input | 1 | Global flag of the new entry |
| ld_pfn | input | PFN_W | Frame number of the new entry |
| ld_cache | input | 1 | Cacheable flag of the new entry |
| ld_read | input | 1 | Readable flag of the new entry |
| ld_write | input | 1 | Writable flag of the new entry |
| ld_exec | input | 1 | Executable flag of the new entry |

## Verification
The translation is exercised with requests that reach one set holding two live entries in different ways, one private and one global. Each request is also paired with a matching, a wrong and an unrelated process identifier, which separates the effect of the identifier compare from the effect of the global flag. Each access kind is run against entries whose flag patterns differ, and every kind is repeated with and without the I/O override, so that a swapped flag or a wrongly scoped override changes a result. Pages whose set bits match a live entry while their upper bits differ, together with entries overwritten by unused page numbers, tell a true tag compare apart from a compare on the index alone. A burst held under back-pressure shows that results stay stable and come out in order.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W = 20;
  localparam int OFF_W = 12;
  localparam int VA_W  = VPN_W + OFF_W;

  typedef enum logic [1:0] {
    ACC_FETCH    = 2'b00,
    ACC_READ     = 2'b01,
    ACC_WRITE    = 2'b10,
    ACC_READ_ALT = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/xlat_way.sv
// One way of the array: tag and data RAMs with a registered, enable-gated read.
module xlat_way #(
  parameter int SETS  = 16,
  parameter int TAG_W = 29,
  parameter int DAT_W = 24,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [DAT_W-1:0] wr_dat,
  output logic [TAG_W-1:0] rd_tag,
  output logic [DAT_W-1:0] rd_dat
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [DAT_W-1:0] dat_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      dat_mem[wr_idx] <= wr_dat;
    end
  end

  // Read-before-write: a load on the reading edge shows up on later lookups.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag <= tag_mem[rd_idx];
      rd_dat <= dat_mem[rd_idx];
    end
  end
endmodule

// File: rtl/xlat_match.sv
// Tag compare across all ways; the lowest-numbered matching way wins.
module xlat_match import xlat_pkg::*; #(
  parameter int NUM_WAYS = 16,
  parameter int PID_W    = 8,
  parameter int DAT_W    = 24,
  localparam int TAG_W   = VPN_W + PID_W + 1
) (
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
  input  logic [NUM_WAYS-1:0][DAT_W-1:0] dats,
  input  logic [VPN_W-1:0]               vpn,
  input  logic [PID_W-1:0]               pid,
  output logic                           hit,
  output logic [DAT_W-1:0]               dat_sel
);
  logic [NUM_WAYS-1:0] way_hit;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    logic [VPN_W-1:0] t_vpn;
    logic [PID_W-1:0] t_pid;
    logic             t_glb;
    assign t_vpn = tags[w][TAG_W-1 -: VPN_W];
    assign t_pid = tags[w][PID_W:1];
    assign t_glb = tags[w][0];
    assign way_hit[w] = (t_vpn == vpn) && (t_glb || (t_pid == pid));
  end

  always_comb begin
    dat_sel = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) dat_sel = dats[w];
    end
  end

  assign hit = |way_hit;
endmodule

// File: rtl/xlat_perm.sv
// Permission check and effective cacheability for one matched entry.
module xlat_perm import xlat_pkg::*; (
  input  logic       hit,
  input  logic [1:0] kind,
  input  logic       io,
  input  logic       f_cache,
  input  logic       f_read,
  input  logic       f_write,
  input  logic       f_exec,
  output logic       fault,
  output logic       cacheable
);
  logic allowed;
  logic is_data;

  always_comb begin
    case (acc_kind_e'(kind))
      ACC_FETCH: allowed = f_exec;
      ACC_WRITE: allowed = f_write;
      default:   allowed = f_read;
    endcase
  end

  assign is_data   = (acc_kind_e'(kind) != ACC_FETCH);
  assign fault     = hit && !allowed;
  assign cacheable = hit && f_cache && !(io && is_data);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer import xlat_pkg::*; #(
  parameter int NUM_WAYS    = 16,
  parameter int NUM_ENTRIES = 256,
  parameter int PID_W       = 8,
  parameter int PFN_W       = 20,
  localparam int WAY_W      = $clog2(NUM_WAYS),
  localparam int PA_W       = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_io,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_miss,
  output logic             rsp_cacheable,
  output logic             rsp_fault,
  input  logic             ld_en,
  input  logic [WAY_W-1:0] ld_way,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [PID_W-1:0] ld_pid,
  input  logic             ld_global,
  input  logic [PFN_W-1:0] ld_pfn,
  input  logic             ld_cache,
  input  logic             ld_read,
  input  logic             ld_write,
  input  logic             ld_exec
);
  localparam int SETS  = NUM_ENTRIES / NUM_WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W + PID_W + 1;
  localparam int DAT_W = PFN_W + 4;

  // Whole-pipeline advance: response slot empty or being drained.
  logic adv;
  assign adv       = !rsp_valid || rsp_ready;
  assign req_ready = adv;

  // Stage 1: request captured alongside the RAM read.
  logic             s1_valid;
  logic [VA_W-1:0]  s1_vaddr;
  logic [1:0]       s1_kind;
  logic             s1_io;
  logic [PID_W-1:0] s1_pid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_vaddr <= '0;
      s1_kind  <= '0;
      s1_io    <= 1'b0;
      s1_pid   <= '0;
    end else if (adv) begin
      s1_valid <= req_valid;
      s1_vaddr <= req_vaddr;
      s1_kind  <= req_kind;
      s1_io    <= req_io;
      s1_pid   <= cur_pid;
    end
  end

  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [DAT_W-1:0] wr_dat;

  assign rd_idx = req_vaddr[OFF_W +: IDX_W];
  assign wr_idx = ld_vpn[IDX_W-1:0];
  assign wr_tag = {ld_vpn, ld_pid, ld_global};
  assign wr_dat = {ld_pfn, ld_cache, ld_read, ld_write, ld_exec};

  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag;
  logic [NUM_WAYS-1:0][DAT_W-1:0] way_dat;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    xlat_way #(
      .SETS  (SETS),
      .TAG_W (TAG_W),
      .DAT_W (DAT_W)
    ) u_way (
      .clk    (clk),
      .rd_en  (adv),
      .rd_idx (rd_idx),
      .wr_en  (ld_en && (ld_way == WAY_W'(w))),
      .wr_idx (wr_idx),
      .wr_tag (wr_tag),
      .wr_dat (wr_dat),
      .rd_tag (way_tag[w]),
      .rd_dat (way_dat[w])
    );
  end

  // Stage 2: compare, permission, registered result.
  logic             hit;
  logic [DAT_W-1:0] sel_dat;

  xlat_match #(
    .NUM_WAYS (NUM_WAYS),
    .PID_W    (PID_W),
    .DAT_W    (DAT_W)
  ) u_match (
    .tags    (way_tag),
    .dats    (way_dat),
    .vpn     (s1_vaddr[VA_W-1 -: VPN_W]),
    .pid     (s1_pid),
    .hit     (hit),
    .dat_sel (sel_dat)
  );

  logic fault_c;
  logic cache_c;

  xlat_perm u_perm (
    .hit       (hit),
    .kind      (s1_kind),
    .io        (s1_io),
    .f_cache   (sel_dat[3]),
    .f_read    (sel_dat[2]),
    .f_write   (sel_dat[1]),
    .f_exec    (sel_dat[0]),
    .fault     (fault_c),
    .cacheable (cache_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_miss      <= 1'b0;
      rsp_cacheable <= 1'b0;
      rsp_fault     <= 1'b0;
    end else if (adv) begin
      rsp_valid     <= s1_valid;
      rsp_paddr     <= hit ? {sel_dat[DAT_W-1 -: PFN_W], s1_vaddr[OFF_W-1:0]} : '0;
      rsp_miss      <= !hit;
      rsp_cacheable <= cache_c;
      rsp_fault     <= fault_c;
    end
  end
endmodule

// File: rtl/xlat_buffer_sva.sv
module xlat_buffer_sva #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_miss,
  input logic            rsp_cacheable,
  input logic            rsp_fault
);
  // Requests accepted but not yet handed out; the pipeline holds at most two.
  logic [2:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 3'(req_valid && req_ready) - 3'(rsp_valid && rsp_ready);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !rsp_valid && req_ready);

  assert_miss_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> !rsp_fault && !rsp_cacheable && (rsp_paddr == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_miss)
      && $stable(rsp_cacheable) && $stable(rsp_fault));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight <= 3'd2) && (rsp_valid -> inflight != 3'd0));
endmodule

bind xlat_buffer xlat_buffer_sva #(.PA_W(PA_W)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_miss      (rsp_miss),
  .rsp_cacheable (rsp_cacheable),
  .rsp_fault     (rsp_fault)
);

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cur_pid = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_io = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_miss, rsp_cacheable, rsp_fault;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_way = '0;
  logic [19:0] ld_vpn = '0;
  logic [7:0]  ld_pid = '0;
  logic        ld_global = 1'b0;
  logic [19:0] ld_pfn = '0;
  logic        ld_cache = 1'b0, ld_read = 1'b0, ld_write = 1'b0, ld_exec = 1'b0;

  xlat_buffer u_xlat_buffer (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] way, input logic [19:0] vpn, input logic [7:0] pid,
                      input logic g, input logic [19:0] pfn, input logic [3:0] crwx);
    @(negedge clk);
    ld_en = 1'b1; ld_way = way; ld_vpn = vpn; ld_pid = pid; ld_global = g; ld_pfn = pfn;
    {ld_cache, ld_read, ld_write, ld_exec} = crwx;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // One request, response checked one edge after acceptance.
  task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic io,
                        input logic [7:0] pid, input logic e_miss, input logic [31:0] e_pa,
                        input logic e_c, input logic e_f, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_io = io; cur_pid = pid;
    chk(req_ready === 1'b1, {req, " ready"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    cur_pid = ~pid;
    chk(rsp_valid === 1'b0, "R2 latency early", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R2 latency", 32'(rsp_valid), 32'd1);
    chk(rsp_miss === e_miss, {req, " miss"}, 32'(rsp_miss), 32'(e_miss));
    chk(rsp_paddr === e_pa, {req, " paddr"}, rsp_paddr, e_pa);
    chk(rsp_cacheable === e_c, {req, " cacheable"}, 32'(rsp_cacheable), 32'(e_c));
    chk(rsp_fault === e_f, {req, " fault"}, 32'(rsp_fault), 32'(e_f));
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic        io;
    logic [7:0]  pid;
    logic        miss;
    logic [31:0] pa;
    logic        c;
    logic        f;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h12345678, 2'b01, 1'b0, 8'h21, 1'b0, 32'hABCDE678, 1'b1, 1'b0}, // R2 read hit
    '{32'h12345678, 2'b10, 1'b0, 8'h21, 1'b0, 32'hABCDE678, 1'b1, 1'b1}, // R6 write, no W
    '{32'h12345678, 2'b00, 1'b0, 8'h21, 1'b0, 32'hABCDE678, 1'b1, 1'b1}, // R6 fetch, no X
    '{32'h12345678, 2'b01, 1'b1, 8'h21, 1'b0, 32'hABCDE678, 1'b0, 1'b0}, // R7 io read
    '{32'h12345678, 2'b01, 1'b0, 8'h22, 1'b1, 32'h00000000, 1'b0, 1'b0}, // R4 pid mismatch
    '{32'h00AA5000, 2'b01, 1'b0, 8'h99, 1'b0, 32'h11111000, 1'b0, 1'b0}, // R5 global
    '{32'h00AA5FFF, 2'b00, 1'b0, 8'h00, 1'b0, 32'h11111FFF, 1'b0, 1'b0}, // R5 global fetch
    '{32'h7777A123, 2'b01, 1'b0, 8'h05, 1'b0, 32'h22222123, 1'b1, 1'b1}, // R6 read, no R
    '{32'h7777A123, 2'b00, 1'b1, 8'h05, 1'b0, 32'h22222123, 1'b1, 1'b0}, // R7 fetch ignores io
    '{32'h7777A123, 2'b10, 1'b1, 8'h05, 1'b0, 32'h22222123, 1'b0, 1'b0}, // R7 io write
    '{32'h4000FABC, 2'b11, 1'b0, 8'h33, 1'b0, 32'hFFFFFABC, 1'b1, 1'b0}, // R6 kind 11 = read
    '{32'h4000FABC, 2'b00, 1'b0, 8'h33, 1'b0, 32'hFFFFFABC, 1'b1, 1'b1}, // R6 fetch, no X
    '{32'h99999000, 2'b01, 1'b0, 8'h21, 1'b1, 32'h00000000, 1'b0, 1'b0}, // R3 empty set
    '{32'h1234F678, 2'b01, 1'b0, 8'h21, 1'b1, 32'h00000000, 1'b0, 1'b0}  // R3 other set
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [31:0] pa_a;

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 in reset valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 after reset valid", 32'(rsp_valid), 32'd0);
    chk(req_ready === 1'b1, "R1 after reset ready", 32'(req_ready), 32'd1);

    // Retire every entry with an unused page number (R9 style fill).
    for (int w = 0; w < 16; w++)
      for (int s = 0; s < 16; s++)
        load(4'(w), 20'hFFF00 | 20'(w << 4) | 20'(s), 8'h00, 1'b0, 20'h0, 4'b0000);

    load(4'd3,  20'h12345, 8'h21, 1'b0, 20'hABCDE, 4'b1100); // R8 way 3 set 5
    load(4'd7,  20'h00AA5, 8'h21, 1'b1, 20'h11111, 4'b0111); // R8 way 7 set 5
    load(4'd0,  20'h7777A, 8'h05, 1'b0, 20'h22222, 4'b1011);
    load(4'd15, 20'h4000F, 8'h33, 1'b0, 20'hFFFFF, 4'b1110);

    for (int i = 0; i < NV; i++)
      lookup(VECS[i].va, VECS[i].kind, VECS[i].io, VECS[i].pid, VECS[i].miss,
             VECS[i].pa, VECS[i].c, VECS[i].f, $sformatf("vec%0d", i));

    // R9: retire way 3 of set 5; R8: way 7 of the same set is untouched.
    load(4'd3, 20'hFFF35, 8'h00, 1'b0, 20'h0, 4'b0000);
    lookup(32'h12345678, 2'b01, 1'b0, 8'h21, 1'b1, 32'h0, 1'b0, 1'b0, "R9 retired");
    lookup(32'h00AA5000, 2'b01, 1'b0, 8'h21, 1'b0, 32'h11111000, 1'b0, 1'b0, "R8 other way");
    // R8: overwrite way 7 in place with new frame and flags.
    load(4'd7, 20'h00AA5, 8'h44, 1'b0, 20'h33333, 4'b1100);
    lookup(32'h00AA5010, 2'b01, 1'b0, 8'h44, 1'b0, 32'h33333010, 1'b1, 1'b0, "R8 rewrite");
    lookup(32'h00AA5010, 2'b01, 1'b0, 8'h21, 1'b1, 32'h0, 1'b0, 1'b0, "R4 rewrite pid");

    // R10: two requests under back-pressure.
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = 32'h7777A456; req_kind = 2'b10; req_io = 1'b0; cur_pid = 8'h05;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 second accept", 32'(req_ready), 32'd1);
    req_vaddr = 32'h4000F001; req_kind = 2'b01; cur_pid = 8'h33;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R10 first valid", 32'(rsp_valid), 32'd1);
    chk(req_ready === 1'b0, "R10 stall ready", 32'(req_ready), 32'd0);
    pa_a = rsp_paddr;
    repeat (3) @(negedge clk);
    chk(rsp_paddr === 32'h22222456 && pa_a === 32'h22222456, "R10 held first",
        rsp_paddr, 32'h22222456);
    chk(rsp_valid === 1'b1 && req_ready === 1'b0, "R10 held valid", 32'(rsp_valid), 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R10 second valid", 32'(rsp_valid), 32'd1);
    chk(rsp_paddr === 32'hFFFFF001, "R10 order", rsp_paddr, 32'hFFFFF001);
    chk(rsp_fault === 1'b0 && rsp_cacheable === 1'b1, "R10 second flags",
        {30'd0, rsp_fault, rsp_cacheable}, 32'd1);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10 drained", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule